// File: doc/BRIEF.md
# Multicast Inter-Processor Interrupt Dispatcher

This block holds a small set of inter-processor interrupt channels shared by up to fifteen processors. Each channel owns a vector/priority word and a target set, one bit per processor. A processor posts an interrupt by writing a bit set of processors to a channel's dispatch register in its private register window. The written bits are merged into the channel's target set, and the channel fires a one-cycle trigger toward the priority logic.

The target set also records which processors have not yet taken the interrupt. Each acknowledge removes one processor from the set. On an edge-type channel, the channel then fires again for the processors that are still waiting. The channel's activity flag is set again each time it fires and drops when the last target acknowledges. Priority arbitration and vector delivery sit downstream and are not part of this block.

Registers are reached through one write port and one combinational read port. Both share a 17-bit address: bits 16:12 select a processor's private 4 KiB window, and bits 11:0 select a register within it.

Top module: `ipi_dispatch`

## Requirements
- R1: After a synchronous reset, every channel's target set reads 0x00000000, every vector/priority word reads 0x80000000 (masked), and all pending and trigger outputs are 0.
- R2: The vector/priority word of channel c sits at window offset 0x800 + 0x20*c. A write stores only the bits in 0x800F00FF. Bit 30 reads back the channel's activity (pending) flag and cannot be written. Bit 22 reads back the channel's sense type (0 = edge, the default) and cannot be written.
- R3: The target set of channel c sits at window offset 0x810 + 0x20*c. A write replaces it and keeps only bits 31:30 and bits [NUM_CPU-1:0]; every other bit reads back 0.
- R4: A write to dispatch offset 0x40 + 0x10*c merges the written value, filtered as in R3, into channel c's target set with a bitwise OR; bits already set stay set. The dispatch register reads as 0.
- R5: After a dispatch, if the channel's processor bits are nonzero and the channel is unmasked, irq_trigger[c] is high for exactly the one cycle after the write and irq_pending[c] becomes 1. A dispatch that leaves the processor bits all zero fires nothing.
- R6: An acknowledge of channel c by processor k clears bit k of that channel's target set and clears irq_pending[c], unless R7 fires the channel again.
- R7: On an edge-type channel, if processor bits remain set after an acknowledge, the channel fires again: a one-cycle trigger, with pending and activity set again. The acknowledge that empties the set fires nothing and leaves pending at 0.
- R8: While bit 31 (mask) of a channel's vector/priority word is 1, that channel produces no trigger and its pending flag stays 0. Its target set is still updated.
- R9: A dispatch and an acknowledge on the same channel in the same cycle both take effect. The acknowledged bit is cleared first, then the dispatch bits are ORed in.
- R10: The processor index is address bits 16:12, so each window is 0x1000 long. Writes are ignored, and reads return 0, when the index is not below NUM_CPU or when address bits 3:0 are nonzero. An acknowledge whose processor index is not below NUM_CPU is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 17 | Write address: processor window in bits 16:12, offset in bits 11:0 |
| wr_data | input | 32 | Write data |
| rd_addr | input | 17 | Read address, same layout as wr_addr |
| rd_data | output | 32 | Combinational read data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | 4 | Index of the acknowledging processor |
| ack_chan | input | 2 | Channel being acknowledged |
| irq_pending | output | 4 | Per-channel pending (activity) flag |
| irq_trigger | output | 4 | Per-channel one-cycle trigger pulse |

## Verification
On every cycle, the assertions check the following:
- a dispatch leaves every written bit set in the target set;
- an acknowledge leaves the acknowledged bit clear;
- a trigger is always matched by a pending flag and traced to a dispatch or acknowledge in the cycle before;
- no trigger follows a cycle in which the channel was masked;
- target sets read as empty on the first cycle after reset.

The directed scenarios cover what needs a sequence of steps: a multicast set draining one acknowledge at a time with a refire after each, the silent final acknowledge, the same-cycle dispatch and acknowledge, the read-back filtering of both words, and the rejection of out-of-window, misaligned and invalid-processor accesses.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int REG_W = 32;
    localparam int OFS_W = 12;

    // Window offsets (processor window selected by address bits above OFS_W)
    localparam logic [OFS_W-1:0] DISP_BASE   = 12'h040;
    localparam int               DISP_STRIDE = 16;
    localparam logic [OFS_W-1:0] CFG_BASE    = 12'h800;
    localparam int               CFG_STRIDE  = 32;
    localparam int               DEST_OFS    = 16;

    // Vector/priority word layout
    localparam logic [REG_W-1:0] VP_WR_MASK   = 32'h800F_00FF;
    localparam logic [REG_W-1:0] VP_RESET     = 32'h8000_0000;
    localparam int               VP_MASK_BIT  = 31;
    localparam int               VP_ACT_BIT   = 30;
    localparam int               VP_SENSE_BIT = 22;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_DISPATCH,
        ACC_VECPRI,
        ACC_DEST
    } acc_kind_e;

    typedef struct packed {
        logic      hit;
        acc_kind_e kind;
        logic [7:0] chan;
    } reg_sel_t;

    // Bits a target-set word keeps: the two flag bits plus one per processor.
    function automatic logic [REG_W-1:0] dest_keep_mask(input int num_cpu);
        logic [REG_W-1:0] m;
        m = 32'hC000_0000;
        for (int k = 0; k < num_cpu; k++) begin
            m[k] = 1'b1;
        end
        return m;
    endfunction

    // Maps a window offset onto a register kind and channel.
    function automatic reg_sel_t decode_offset(input logic [OFS_W-1:0] ofs,
                                               input int num_chan);
        reg_sel_t s;
        s = '{hit: 1'b0, kind: ACC_NONE, chan: 8'd0};
        for (int c = 0; c < num_chan; c++) begin
            if (ofs == DISP_BASE + OFS_W'(c * DISP_STRIDE)) begin
                s = '{hit: 1'b1, kind: ACC_DISPATCH, chan: 8'(c)};
            end
            if (ofs == CFG_BASE + OFS_W'(c * CFG_STRIDE)) begin
                s = '{hit: 1'b1, kind: ACC_VECPRI, chan: 8'(c)};
            end
            if (ofs == CFG_BASE + OFS_W'(c * CFG_STRIDE + DEST_OFS)) begin
                s = '{hit: 1'b1, kind: ACC_DEST, chan: 8'(c)};
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CPU  = 15,
    parameter int NUM_CHAN = 4,
    parameter int ADDR_W   = 17
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int IDX_W = ADDR_W - OFS_W;

    logic [IDX_W-1:0] cpu_idx;
    logic             window_ok;
    reg_sel_t         raw;

    assign cpu_idx   = addr[ADDR_W-1:OFS_W];
    assign window_ok = en && (addr[3:0] == 4'h0) && (int'(cpu_idx) < NUM_CPU);
    assign raw       = decode_offset(addr[OFS_W-1:0], NUM_CHAN);

    always_comb begin
        sel = raw;
        if (!window_ok) begin
            sel.hit  = 1'b0;
            sel.kind = ACC_NONE;
        end
    end

endmodule

// File: rtl/ipi_channel.sv
module ipi_channel
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 15,
    parameter int CPU_W   = 4,
    parameter bit LEVEL   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disp_we,
    input  logic             vp_we,
    input  logic             dm_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             ack_hit,
    input  logic [CPU_W-1:0] ack_cpu,
    output logic [REG_W-1:0] vp_view,
    output logic [REG_W-1:0] dest_view,
    output logic             pending,
    output logic             trig
);
    localparam logic [REG_W-1:0] KEEP     = dest_keep_mask(NUM_CPU);
    localparam logic [REG_W-1:0] CPU_BITS = KEEP & 32'h3FFF_FFFF;

    logic [REG_W-1:0] vp_q;
    logic [REG_W-1:0] dest_q;
    logic [REG_W-1:0] dest_d;
    logic [REG_W-1:0] ack_clr;
    logic [REG_W-1:0] wkeep;
    logic             targets_left;
    logic             want_fire;
    logic             fire;

    always_comb begin
        ack_clr = '0;
        for (int k = 0; k < NUM_CPU; k++) begin
            if (ack_hit && ack_cpu == CPU_W'(k)) begin
                ack_clr[k] = 1'b1;
            end
        end
    end

    assign wkeep = wdata & KEEP;

    always_comb begin
        if (dm_we) begin
            dest_d = wkeep;
        end else begin
            dest_d = (dest_q & ~ack_clr) | (disp_we ? wkeep : '0);
        end
    end

    assign targets_left = |(dest_d & CPU_BITS);
    assign want_fire    = targets_left && (disp_we || (ack_hit && !LEVEL));
    assign fire         = want_fire && !vp_q[VP_MASK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            vp_q    <= VP_RESET;
            dest_q  <= '0;
            pending <= 1'b0;
            trig    <= 1'b0;
        end else begin
            if (vp_we) begin
                vp_q <= wdata & VP_WR_MASK;
            end
            dest_q <= dest_d;
            trig   <= fire;
            if (fire) begin
                pending <= 1'b1;
            end else if (ack_hit) begin
                pending <= 1'b0;
            end
        end
    end

    always_comb begin
        vp_view               = vp_q;
        vp_view[VP_ACT_BIT]   = pending;
        vp_view[VP_SENSE_BIT] = LEVEL;
    end

    assign dest_view = dest_q;

    // R1: target set empty on the first cycle after reset
    a_r1_dest_empty_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (dest_q == '0));

    // R4: every written bit is present after a dispatch
    a_r4_dispatch_bits_set: assert property (@(posedge clk) disable iff (rst)
        (disp_we && !dm_we) |=> ((dest_q & $past(wkeep)) == $past(wkeep)));

    // R6: acknowledged bit is clear afterwards
    a_r6_ack_bit_cleared: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && !disp_we && !dm_we) |=> ((dest_q & $past(ack_clr)) == '0));

    // R5: a trigger is always accompanied by pending
    a_r5_trig_has_pending: assert property (@(posedge clk) disable iff (rst)
        trig |-> pending);

    // R7: a trigger has a dispatch or acknowledge as its cause
    a_r7_trig_has_cause: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(disp_we || ack_hit));

    // R8: no trigger out of a masked cycle
    a_r8_masked_no_trig: assert property (@(posedge clk) disable iff (rst)
        trig |-> !$past(vp_q[VP_MASK_BIT]));

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipi_pkg::*;
#(
    parameter int NUM_CPU  = 15,
    parameter int NUM_CHAN = 4,
    parameter int ADDR_W   = 17,
    parameter int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    parameter int CHAN_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
    parameter logic [NUM_CHAN-1:0] LEVEL_CHANS = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [REG_W-1:0]    rd_data,
    input  logic                ack_valid,
    input  logic [CPU_W-1:0]    ack_cpu,
    input  logic [CHAN_W-1:0]   ack_chan,
    output logic [NUM_CHAN-1:0] irq_pending,
    output logic [NUM_CHAN-1:0] irq_trigger
);
    reg_sel_t         wsel;
    reg_sel_t         rsel;
    logic             ack_ok;
    logic [REG_W-1:0] vp_view   [NUM_CHAN];
    logic [REG_W-1:0] dest_view [NUM_CHAN];

    ipi_addr_decode #(.NUM_CPU(NUM_CPU), .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) i_wdec (
        .en   (wr_en),
        .addr (wr_addr),
        .sel  (wsel)
    );

    ipi_addr_decode #(.NUM_CPU(NUM_CPU), .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) i_rdec (
        .en   (1'b1),
        .addr (rd_addr),
        .sel  (rsel)
    );

    assign ack_ok = ack_valid && (int'(ack_cpu) < NUM_CPU);

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic chan_sel;
        assign chan_sel = wsel.hit && (wsel.chan == 8'(c));

        ipi_channel #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .LEVEL(LEVEL_CHANS[c])) i_chan (
            .clk       (clk),
            .rst       (rst),
            .disp_we   (chan_sel && wsel.kind == ACC_DISPATCH),
            .vp_we     (chan_sel && wsel.kind == ACC_VECPRI),
            .dm_we     (chan_sel && wsel.kind == ACC_DEST),
            .wdata     (wr_data),
            .ack_hit   (ack_ok && ack_chan == CHAN_W'(c)),
            .ack_cpu   (ack_cpu),
            .vp_view   (vp_view[c]),
            .dest_view (dest_view[c]),
            .pending   (irq_pending[c]),
            .trig      (irq_trigger[c])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (rsel.hit && rsel.chan == 8'(c)) begin
                if (rsel.kind == ACC_VECPRI) begin
                    rd_data = vp_view[c];
                end else if (rsel.kind == ACC_DEST) begin
                    rd_data = dest_view[c];
                end
            end
        end
    end

    // R10: an acknowledge from a nonexistent processor never triggers anything
    a_r10_bad_ack_silent: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_ok && !wr_en) |=> (irq_trigger == '0));

endmodule

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [16:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_cpu = '0;
    logic [1:0]  ack_chan = '0;
    logic [3:0]  irq_pending;
    logic [3:0]  irq_trigger;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ipi_dispatch i_ipi_dispatch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ack_valid(ack_valid),
        .ack_cpu(ack_cpu), .ack_chan(ack_chan),
        .irq_pending(irq_pending), .irq_trigger(irq_trigger)
    );

    function automatic logic [16:0] vp_addr(input int c);
        return 17'(32'h800 + c * 32);
    endfunction
    function automatic logic [16:0] dm_addr(input int c);
        return 17'(32'h810 + c * 32);
    endfunction
    function automatic logic [16:0] disp_addr(input int cpu, input int c);
        return 17'(cpu * 4096 + 32'h40 + c * 16);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [16:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [16:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack(input int cpu, input int c);
        @(negedge clk);
        ack_valid = 1'b1; ack_cpu = 4'(cpu); ack_chan = 2'(c);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic wr_and_ack(input logic [16:0] a, input logic [31:0] d,
                              input int cpu, input int c);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        ack_valid = 1'b1; ack_cpu = 4'(cpu); ack_chan = 2'(c);
        @(negedge clk);
        wr_en = 1'b0; ack_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin
            rd(vp_addr(c), d);  check("R1", "vecpri reset", d, 32'h8000_0000);
            rd(dm_addr(c), d);  check("R1", "targets reset", d, 32'h0);
        end
        check("R1", "pending reset", 32'(irq_pending), 32'h0);
        check("R1", "trigger reset", 32'(irq_trigger), 32'h0);
    endtask

    task automatic t_config_words;
        logic [31:0] d;
        wr(vp_addr(1), 32'hFFFF_FFFF);
        rd(vp_addr(1), d);  check("R2", "vecpri filter", d, 32'h800F_00FF);
        wr(vp_addr(1), 32'h0005_00AB);
        rd(vp_addr(1), d);  check("R2", "vecpri unmask", d, 32'h0005_00AB);
        wr(dm_addr(1), 32'hFFFF_FFFF);
        rd(dm_addr(1), d);  check("R3", "targets filter", d, 32'hC000_7FFF);
        wr(dm_addr(1), 32'h0);
        rd(dm_addr(1), d);  check("R3", "targets replaced", d, 32'h0);
        rd(disp_addr(0, 1), d); check("R4", "dispatch reads zero", d, 32'h0);
    endtask

    task automatic t_multicast_drain;
        logic [31:0] d;
        wr(vp_addr(0), 32'h0003_0010);
        wr(disp_addr(2, 0), 32'h5);
        check("R5", "trigger after dispatch", 32'(irq_trigger), 32'h1);
        check("R5", "pending after dispatch", 32'(irq_pending), 32'h1);
        @(negedge clk);
        check("R5", "trigger one cycle", 32'(irq_trigger), 32'h0);
        wr(disp_addr(3, 0), 32'h8);
        rd(dm_addr(0), d);  check("R4", "OR merge", d, 32'hD);
        ack(0, 0);
        rd(dm_addr(0), d);  check("R6", "ack clears cpu0", d, 32'hC);
        check("R7", "refire after ack", 32'(irq_trigger), 32'h1);
        rd(vp_addr(0), d);  check("R7", "activity set again", d, 32'h4003_0010);
        ack(2, 0);
        rd(dm_addr(0), d);  check("R6", "ack clears cpu2", d, 32'h8);
        check("R7", "second refire", 32'(irq_trigger), 32'h1);
        ack(3, 0);
        rd(dm_addr(0), d);  check("R6", "last ack empties", d, 32'h0);
        check("R7", "no refire when empty", 32'(irq_trigger), 32'h0);
        check("R6", "pending cleared", 32'(irq_pending), 32'h0);
        wr(disp_addr(0, 0), 32'h0);
        check("R5", "empty dispatch silent", 32'(irq_trigger), 32'h0);
        check("R5", "empty dispatch no pending", 32'(irq_pending), 32'h0);
    endtask

    task automatic t_masked;
        logic [31:0] d;
        wr(disp_addr(1, 2), 32'h2);
        check("R8", "masked no trigger", 32'(irq_trigger), 32'h0);
        check("R8", "masked no pending", 32'(irq_pending), 32'h0);
        rd(dm_addr(2), d);  check("R8", "masked targets updated", d, 32'h2);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d;
        wr(vp_addr(3), 32'h0000_0010);
        wr(disp_addr(0, 3), 32'h3);
        wr_and_ack(disp_addr(0, 3), 32'h1, 0, 3);
        rd(dm_addr(3), d);  check("R9", "ack then OR", d, 32'h3);
        check("R9", "fires", 32'(irq_trigger), 32'h8);
        wr_and_ack(disp_addr(0, 3), 32'h4, 1, 3);
        rd(dm_addr(3), d);  check("R9", "ack cpu1 plus cpu2", d, 32'h5);
    endtask

    task automatic t_rejects;
        logic [31:0] d;
        wr(17'h0F040, 32'h10);
        rd(dm_addr(0), d);  check("R10", "cpu15 window ignored", d, 32'h0);
        wr(17'h00044, 32'h10);
        rd(dm_addr(0), d);  check("R10", "misaligned ignored", d, 32'h0);
        check("R10", "no trigger from rejects", 32'(irq_trigger), 32'h0);
        rd(17'h0F870, d);   check("R10", "cpu15 read zero", d, 32'h0);
        rd(17'h03870, d);   check("R10", "cpu3 window alias", d, 32'h5);
        ack(15, 3);
        rd(dm_addr(3), d);  check("R10", "bad ack ignored", d, 32'h5);
        check("R10", "bad ack silent", 32'(irq_trigger), 32'h0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_config_words();
        t_multicast_drain();
        t_masked();
        t_same_cycle();
        t_rejects();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule